// File: doc/BRIEF.md
# Prioritized Interrupt Level Recognizer

This block sits between an encoded three-bit external interrupt request and the exception sequencer of a processor core. It synchronizes the request into the bus clock domain and accepts a level only after it has been stable for two consecutive samples. It compares that level against the three-bit priority mask held in the status register. When an interrupt is pending it reports the interrupt and its level. The core takes the interrupt at an instruction boundary if no higher-priority exception is outstanding.

Level 7 cannot be masked, but it is recognized only when the request moves into level 7 from a lower level. Levels 1 to 6 are level-sensitive. Once an interrupt is taken, the block either produces an autovector internally or asks for an external acknowledge cycle and returns the vector that cycle delivers. It then refuses any further interrupt until the handler has retired one instruction.

Top module: `irq_level_recognizer`

## Requirements
- R1: After reset, `irq_pend_o`, `ack_req_o` and `vec_valid_o` are all 0.
- R2: The request passes through two synchronizing flops. A level is qualified only when the same value is seen on two consecutive synchronized samples. A change that lasts a single clock never produces a pending interrupt.
- R3: An encoded request of 0 means no request. Levels 1 to 6 are pending only when the qualified level is strictly greater than the mask value `sr_mask_i`.
- R4: Levels 1 to 6 are level-sensitive. They stay pending while the qualified level remains above the mask, they pend again after service if still asserted, and they stop pending once the request is withdrawn.
- R5: Level 7 ignores the mask and is edge-triggered. A transition from any lower qualified level (including 0) into 7 makes one interrupt pending. A level 7 request held continuously yields exactly one interrupt. Dropping to a lower level re-arms the detector.
- R6: A pending interrupt is taken only on a clock where `boundary_i` is 1 and `higher_exc_i` is 0. While `higher_exc_i` is 1 nothing is taken and the interrupt stays pending.
- R7: If the autovector enable bit for the taken level is 1 (`avec_en_i[level-1]`) and `blk_i` is 1, no acknowledge cycle is requested. `vec_valid_o` pulses for one clock, one clock after the take, with vector 24 + level.
- R8: If the autovector enable for the taken level is 0, `ack_req_o` pulses for one clock, one clock after the take. One clock after `ack_done_i`, `vec_valid_o` pulses and carries `ack_data_i` as sampled with `ack_done_i`. `ack_req_o` and `vec_valid_o` are never 1 together.
- R9: If autovectoring is enabled for the level and `blk_i` is 0, the acknowledge cycle is still requested. The vector delivered after `ack_done_i` is 24 + level, not the acknowledge data.
- R10: After a take, `irq_pend_o` stays 0 until one `boundary_i` has been seen after handler entry. Boundaries that occur while the acknowledge cycle is outstanding do not count.
- R11: While no interrupt is in service, `irq_level_o` shows the level of the pending interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 3 | Asynchronous encoded interrupt request, 0 = none |
| sr_mask_i | input | 3 | Status-register interrupt priority mask |
| avec_en_i | input | 7 | Autovector enable per level, bit n-1 for level n |
| blk_i | input | 1 | 1 suppresses the acknowledge cycle for autovectored levels |
| higher_exc_i | input | 1 | A higher-priority exception is pending |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| ack_done_i | input | 1 | External acknowledge cycle complete |
| ack_data_i | input | 8 | Vector returned by the acknowledge cycle |
| irq_pend_o | output | 1 | Interrupt pending and not held off |
| irq_level_o | output | 3 | Pending level when idle, otherwise level in service |
| ack_req_o | output | 1 | One-clock request to run an acknowledge cycle |
| vec_valid_o | output | 1 | One-clock strobe, `vec_o` is valid |
| vec_o | output | 8 | Exception vector number |

## Verification
For levels 1 to 6, a request change applied between edges shows up on `irq_pend_o` after the third rising edge: two edges through the synchronizer and one for the stability compare. A level 7 edge needs a fourth edge for the edge latch. For this reason the bench waits four clocks after every request change before it looks at the pending outputs. `ack_req_o` and the autovector strobe are due on the edge that follows the take edge, and an acknowledge-path vector is due on the edge after `ack_done_i`. The scoreboard monitor samples 1 ns after every rising edge. It pops one expected item per strobe, so a strobe that comes late, early or unasked for is reported as a mismatch or as an unexpected strobe.

// File: rtl/irq_level_recognizer.sv
module irq_level_recognizer #(
  parameter int VEC_W     = 8,
  parameter int AVEC_BASE = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       irq_req_i,
  input  logic [2:0]       sr_mask_i,
  input  logic [6:0]       avec_en_i,
  input  logic             blk_i,
  input  logic             higher_exc_i,
  input  logic             boundary_i,
  input  logic             ack_done_i,
  input  logic [VEC_W-1:0] ack_data_i,
  output logic             irq_pend_o,
  output logic [2:0]       irq_level_o,
  output logic             ack_req_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o
);

  typedef enum logic [1:0] {S_IDLE, S_ACK, S_HOLD} st_t;
  localparam logic [2:0] NMI_LVL = 3'd7;

  st_t        st;
  logic [2:0] sync1, sync2, qlev, qlev_prev, mask_q, taken_lvl;
  logic       nmi_pend, taken_avec;
  logic [2:0] pend_lvl;
  logic [7:0] avec_map;
  logic       lvl_ok, take, av_sel;

  // request synchronizer and two-sample qualifier
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      qlev      <= '0;
      qlev_prev <= '0;
      mask_q    <= NMI_LVL;
    end else begin
      sync1     <= irq_req_i;
      sync2     <= sync1;
      if (sync1 == sync2) qlev <= sync2;
      qlev_prev <= qlev;
      mask_q    <= sr_mask_i;
    end
  end

  assign lvl_ok   = (qlev != 3'd0) && (qlev != NMI_LVL) && (qlev > mask_q);
  assign pend_lvl = nmi_pend ? NMI_LVL : (lvl_ok ? qlev : 3'd0);
  assign avec_map = {avec_en_i, 1'b0};
  assign av_sel   = avec_map[pend_lvl];

  assign irq_pend_o  = (st == S_IDLE) && (pend_lvl != 3'd0);
  assign irq_level_o = (st == S_IDLE) ? pend_lvl : taken_lvl;
  assign take        = irq_pend_o && boundary_i && !higher_exc_i;

  // nonmaskable edge latch
  always_ff @(posedge clk) begin
    if (!rst_n)
      nmi_pend <= 1'b0;
    else if (qlev == NMI_LVL && qlev_prev != NMI_LVL)
      nmi_pend <= 1'b1;
    else if ((take && pend_lvl == NMI_LVL) || qlev != NMI_LVL)
      nmi_pend <= 1'b0;
  end

  // service sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      taken_lvl   <= '0;
      taken_avec  <= 1'b0;
      ack_req_o   <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      ack_req_o   <= 1'b0;
      vec_valid_o <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          taken_lvl  <= pend_lvl;
          taken_avec <= av_sel;
          if (av_sel && blk_i) begin
            vec_valid_o <= 1'b1;
            vec_o       <= VEC_W'(AVEC_BASE) + VEC_W'(pend_lvl);
            st          <= S_HOLD;
          end else begin
            ack_req_o <= 1'b1;
            st        <= S_ACK;
          end
        end
        S_ACK: if (ack_done_i) begin
          vec_valid_o <= 1'b1;
          vec_o       <= taken_avec ? VEC_W'(AVEC_BASE) + VEC_W'(taken_lvl) : ack_data_i;
          st          <= S_HOLD;
        end
        S_HOLD: if (boundary_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_o && irq_level_o != NMI_LVL) |-> (irq_level_o > mask_q));
  p_take_response_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ack_req_o || vec_valid_o));
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_req_o && vec_valid_o));
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |=> !ack_req_o);
  p_avec_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && taken_avec) |-> (vec_o == VEC_W'(AVEC_BASE) + VEC_W'(taken_lvl)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_o || vec_valid_o) |-> !irq_pend_o);

endmodule

// File: tb/tb_irq_level_recognizer.sv
`timescale 1ns/1ps
module tb_irq_level_recognizer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] irq_req = '0, sr_mask = 3'd7;
  logic [6:0] avec_en = '0;
  logic       blk = 1'b0, higher_exc = 1'b0, boundary = 1'b0, ack_done = 1'b0;
  logic [7:0] ack_data = '0;
  logic       irq_pend, ack_req, vec_valid;
  logic [2:0] irq_level;
  logic [7:0] vec;

  int checks = 0, fails = 0;
  bit        qk[$];
  logic [7:0] qv[$];
  string     qt[$];

  always #5 clk = ~clk;

  irq_level_recognizer dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .sr_mask_i(sr_mask),
    .avec_en_i(avec_en), .blk_i(blk), .higher_exc_i(higher_exc),
    .boundary_i(boundary), .ack_done_i(ack_done), .ack_data_i(ack_data),
    .irq_pend_o(irq_pend), .irq_level_o(irq_level), .ack_req_o(ack_req),
    .vec_valid_o(vec_valid), .vec_o(vec));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic push(input bit is_vec, input logic [7:0] v, input string tag);
    qk.push_back(is_vec); qv.push_back(v); qt.push_back(tag);
  endtask

  task automatic set_req(input logic [2:0] l);
    @(negedge clk) irq_req = l;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_boundary();
    @(negedge clk) boundary = 1'b1;
    @(negedge clk) boundary = 1'b0;
  endtask

  task automatic complete_ack(input logic [7:0] d);
    repeat (2) @(negedge clk);
    ack_done = 1'b1; ack_data = d;
    @(negedge clk) ack_done = 1'b0; ack_data = '0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && ack_req) begin
      if (qk.size() == 0 || qk[0]) chk(0, "R8 unexpected ack_req", 1, 0);
      else begin chk(1, qt[0], 1, 1); void'(qk.pop_front()); void'(qv.pop_front()); void'(qt.pop_front()); end
    end
    if (rst_n && vec_valid) begin
      if (qk.size() == 0 || !qk[0]) chk(0, "R7 unexpected vec_valid", int'(vec), 0);
      else begin
        chk(vec == qv[0], qt[0], int'(vec), int'(qv[0]));
        void'(qk.pop_front()); void'(qv.pop_front()); void'(qt.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irq_pend == 0 && ack_req == 0 && vec_valid == 0, "R1 reset outputs", irq_pend, 0);
    rst_n = 1'b1;
    sr_mask = 3'd3;
    set_req(3'd2);
    chk(irq_pend == 0, "R3 level 2 below mask 3", irq_pend, 0);
    set_req(3'd3);
    chk(irq_pend == 0, "R3 level 3 equal to mask", irq_pend, 0);
    set_req(3'd4);
    chk(irq_pend == 1, "R3 level 4 above mask", irq_pend, 1);
    chk(irq_level == 4, "R11 pending level", irq_level, 4);
    set_req(3'd0);
    chk(irq_pend == 0, "R3 request 0 is none", irq_pend, 0);
    // single-clock glitch
    @(negedge clk) irq_req = 3'd5;
    @(negedge clk) irq_req = 3'd0;
    repeat (4) @(negedge clk);
    chk(irq_pend == 0, "R2 one-clock pulse discarded", irq_pend, 0);
    @(negedge clk) irq_req = 3'd5;
    @(negedge clk);
    chk(irq_pend == 0, "R2 not yet qualified", irq_pend, 0);
    repeat (3) @(negedge clk);
    chk(irq_pend == 1, "R2 qualified after two samples", irq_pend, 1);
    // higher-priority exception blocks the take
    higher_exc = 1'b1;
    pulse_boundary();
    @(negedge clk);
    chk(irq_pend == 1, "R6 held by higher exception", irq_pend, 1);
    higher_exc = 1'b0;
    // acknowledge path
    push(0, 8'h00, "R8 ack_req after take");
    push(1, 8'h40, "R8 vector from ack data");
    pulse_boundary();
    chk(irq_pend == 0, "R10 no pending after take", irq_pend, 0);
    pulse_boundary();
    complete_ack(8'h40);
    chk(irq_pend == 0, "R10 ack-time boundary not counted", irq_pend, 0);
    pulse_boundary();
    chk(irq_pend == 1 && irq_level == 5, "R4 level 5 pends again", irq_level, 5);
    set_req(3'd0);
    chk(irq_pend == 0, "R4 withdrawn request", irq_pend, 0);
    // autovector, acknowledge blocked
    avec_en = 7'b0100000; blk = 1'b1;
    set_req(3'd6);
    push(1, 8'd30, "R7 autovector level 6 no ack");
    pulse_boundary();
    repeat (2) @(negedge clk);
    pulse_boundary();
    set_req(3'd0);
    // autovector with acknowledge cycle
    sr_mask = 3'd1; avec_en = 7'b0000010; blk = 1'b0;
    set_req(3'd2);
    chk(irq_pend == 1 && irq_level == 2, "R3 level 2 above mask 1", irq_level, 2);
    push(0, 8'h00, "R9 ack_req with blk 0");
    push(1, 8'd26, "R9 autovector ignores ack data");
    pulse_boundary();
    complete_ack(8'h99);
    pulse_boundary();
    set_req(3'd0);
    // nonmaskable edge
    sr_mask = 3'd7; avec_en = 7'b1000000; blk = 1'b1;
    set_req(3'd7);
    chk(irq_pend == 1 && irq_level == 7, "R5 level 7 ignores mask", irq_level, 7);
    push(1, 8'd31, "R5 level 7 autovector");
    pulse_boundary();
    repeat (2) @(negedge clk);
    pulse_boundary();
    repeat (4) @(negedge clk);
    chk(irq_pend == 0, "R5 held level 7 gives one interrupt", irq_pend, 0);
    set_req(3'd3);
    chk(irq_pend == 0, "R5 level 3 masked by 7", irq_pend, 0);
    set_req(3'd7);
    chk(irq_pend == 1, "R5 re-armed after drop", irq_pend, 1);
    push(1, 8'd31, "R5 second level 7 autovector");
    pulse_boundary();
    pulse_boundary();
    repeat (4) @(negedge clk);
    chk(qk.size() == 0, "R8 all expected strobes seen", qk.size(), 0);
    summary();
  end
endmodule